// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block is the load side of memory disambiguation in an out-of-order core. Loads take a slot at dispatch, strictly in program order. The slot's position, together with a wrap bit, then serves as the load's age tag. When a load executes, the core writes its full byte address and access size into the slot. When a store later resolves its address, the store presents the load-queue tail pointer it captured at its own dispatch. Every load at or after that pointer is younger than the store.

Each store port compares the store against every live slot in parallel. A load counts as a violation only if it has already executed, is younger than the store, and touches at least one byte that the store writes. If any store port finds a violation, the block raises a single squash for the oldest offending store. It drops every younger slot and winds the tail back, so the core can restart fetch from the instruction after that store. Commit retires the head slot.

The queue depth must be a power of two. Accesses are naturally aligned.

Top module: `load_order_guard`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_tag` is 0 and `squash_valid` is 0.
- R2: Each accepted dispatch is handed the current tail pointer on `disp_tag`. The tag is the slot index with a wrap bit above it, so it has log2(DEPTH)+1 bits and counts modulo 2*DEPTH. The tail advances by one for each accepted dispatch.
- R3: While DEPTH loads are live, `disp_ready` is 0. A dispatch attempted in that state is ignored and leaves `disp_tag` unchanged.
- R4: A commit pulse retires the oldest live load and frees its slot, so `disp_ready` returns to 1 after a full queue commits.
- R5: A store whose address overlaps an executed load at or after the store's tail pointer makes `squash_valid` high for exactly the one cycle after the clock edge that sampled the store. In that cycle `squash_sid` carries the store's id.
- R6: A load positioned before the store's tail pointer (older than the store) never causes a squash, even if the addresses overlap.
- R7: A load that has been dispatched but not yet executed never causes a squash.
- R8: Two accesses overlap only when all of the following hold:
  - They share address bits [ADDR_W-1:3].
  - Their byte lanes intersect, where size code 0, 1, 2 or 3 covers 1, 2, 4 or 8 bytes starting at address bits [2:0].
  - For example, adjacent accesses do not overlap.
- R9: When several store ports violate in the same cycle, exactly one squash is reported: the port whose tail pointer is closest to the head. If tail pointers are equal, the lower port index wins.
- R10: On a squash, every load at or after the chosen store's tail pointer is discarded and the tail pointer takes that value. The next `disp_tag` therefore equals it, and discarded loads can no longer cause a squash.
- R11: Age is measured from the head pointer, so the older/younger decision is correct when the slots wrap past the end of the array.
- R12: A dispatch presented in the same cycle that a violation is detected is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | A load asks for a slot |
| disp_ready | output | 1 | A slot is free |
| disp_tag | output | log2(DEPTH)+1 | Age tag given to the dispatching load |
| ex_valid | input | 1 | A load has executed |
| ex_tag | input | log2(DEPTH)+1 | Tag of the executed load |
| ex_addr | input | ADDR_W | Byte address of the executed load |
| ex_size | input | 2 | Size code of the executed load |
| cm_valid | input | 1 | Retire the oldest load |
| st_valid | input | N_ST | Store port has a resolved address |
| st_addr | input | N_ST x ADDR_W | Store byte address per port |
| st_size | input | N_ST x 2 | Store size code per port |
| st_ltail | input | N_ST x (log2(DEPTH)+1) | Load-queue tail captured when the store dispatched |
| st_sid | input | N_ST x SID_W | Store identifier per port |
| squash_valid | output | 1 | Restart request |
| squash_sid | output | SID_W | Store after which to restart |

## Verification
The slot outputs `disp_ready` and `disp_tag` come from registered state. Their effect appears right after the clock edge that samples a dispatch, commit or squash, and the driver checks them at the following falling edge.

A squash takes one register stage. For each store cycle, the driver queues the outcome it expects, either a store id or no squash. The monitor pops that entry at the very next falling edge and compares it with `squash_valid` and `squash_sid` there. Any squash that arrives in any other cycle is reported as unexpected, so a late or repeated squash cannot pass.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    // Byte lanes touched inside an aligned 8-byte word.
    // The size code gives 1, 2, 4 or 8 bytes; the low address bits give the start lane.
    function automatic logic [7:0] lane_mask(input logic [2:0] lo, input logic [1:0] sz);
        logic [7:0] base;
        case (sz)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            2'd2:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        return base << lo;
    endfunction

endpackage

// File: rtl/ldq_search.sv
// Compares one resolving store against every queue slot in parallel.
module ldq_search #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                                st_valid,
    input  logic [ADDR_W-1:0]                   st_addr,
    input  logic [1:0]                          st_size,
    input  logic [$clog2(DEPTH):0]              st_ltail,
    input  logic [$clog2(DEPTH):0]              head,
    input  logic [DEPTH-1:0]                    ent_live,
    input  logic [DEPTH-1:0][ADDR_W-1:0]        ent_addr,
    input  logic [DEPTH-1:0][1:0]               ent_size,
    output logic                                hit,
    output logic [$clog2(DEPTH):0]              bound
);
    import ldq_pkg::*;

    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [DEPTH-1:0] match_vec;
    logic [7:0]       st_lanes;

    assign st_lanes = lane_mask(st_addr[2:0], st_size);
    // Distance of the store's first younger load from the head.
    assign bound    = st_ltail - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [IW-1:0] off;
        logic          younger;
        logic          same_word;
        logic          lanes_hit;
        assign off       = IW'(i) - head[IW-1:0];
        assign younger   = {1'b0, off} >= bound;
        assign same_word = ent_addr[i][ADDR_W-1:3] == st_addr[ADDR_W-1:3];
        assign lanes_hit = |(lane_mask(ent_addr[i][2:0], ent_size[i]) & st_lanes);
        assign match_vec[i] = ent_live[i] && younger && same_word && lanes_hit;
    end

    assign hit = st_valid && (|match_vec);

endmodule

// File: rtl/ldq_pick.sv
// Chooses the oldest violating store port (closest bound, lower port on tie).
module ldq_pick #(
    parameter int N_ST = 2,
    parameter int PW   = 4,
    parameter int SW   = (N_ST > 1) ? $clog2(N_ST) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_ST-1:0]          viol,
    input  logic [N_ST-1:0][PW-1:0]  bnd,
    output logic                     any,
    output logic [SW-1:0]            sel,
    output logic [PW-1:0]            sel_bnd
);
    always_comb begin
        any     = 1'b0;
        sel     = '0;
        sel_bnd = '0;
        for (int j = 0; j < N_ST; j++) begin
            if (viol[j] && (!any || bnd[j] < sel_bnd)) begin
                any     = 1'b1;
                sel     = SW'(j);
                sel_bnd = bnd[j];
            end
        end
    end

    assert_pick_is_violator_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> viol[sel]);

    for (genvar j = 0; j < N_ST; j++) begin : g_chk
        assert_pick_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (any && viol[j]) |-> (sel_bnd <= bnd[j]));
    end

endmodule

// File: rtl/load_order_guard.sv
module load_order_guard #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int N_ST   = 2,
    parameter int SID_W  = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   disp_valid,
    output logic                                   disp_ready,
    output logic [$clog2(DEPTH):0]                 disp_tag,
    input  logic                                   ex_valid,
    input  logic [$clog2(DEPTH):0]                 ex_tag,
    input  logic [ADDR_W-1:0]                      ex_addr,
    input  logic [1:0]                             ex_size,
    input  logic                                   cm_valid,
    input  logic [N_ST-1:0]                        st_valid,
    input  logic [N_ST-1:0][ADDR_W-1:0]            st_addr,
    input  logic [N_ST-1:0][1:0]                   st_size,
    input  logic [N_ST-1:0][$clog2(DEPTH):0]       st_ltail,
    input  logic [N_ST-1:0][SID_W-1:0]             st_sid,
    output logic                                   squash_valid,
    output logic [SID_W-1:0]                       squash_sid
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam int SW = (N_ST > 1) ? $clog2(N_ST) : 1;

    typedef struct packed {
        logic              vld;
        logic              exe;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
    } slot_t;

    typedef struct packed {
        logic [PW-1:0]          head;
        logic [PW-1:0]          tail;
        slot_t [DEPTH-1:0]      slot;
        logic                   sq_v;
        logic [SID_W-1:0]       sq_sid;
    } state_t;

    state_t s_q, s_d;

    logic [PW-1:0]                  count;
    logic                           full;
    logic [IW-1:0]                  hd_idx, tl_idx, ex_idx;
    logic [DEPTH-1:0]               live;
    logic [DEPTH-1:0][ADDR_W-1:0]   s_addr;
    logic [DEPTH-1:0][1:0]          s_size;
    logic [DEPTH-1:0][IW-1:0]       s_off;
    logic [N_ST-1:0]                viol;
    logic [N_ST-1:0][PW-1:0]        bnd;
    logic                           any_viol;
    logic [SW-1:0]                  sel;
    logic [PW-1:0]                  sel_bnd;

    assign count  = s_q.tail - s_q.head;
    assign full   = count == PW'(DEPTH);
    assign hd_idx = s_q.head[IW-1:0];
    assign tl_idx = s_q.tail[IW-1:0];
    assign ex_idx = ex_tag[IW-1:0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign live[i]   = s_q.slot[i].vld && s_q.slot[i].exe;
        assign s_addr[i] = s_q.slot[i].addr;
        assign s_size[i] = s_q.slot[i].size;
        assign s_off[i]  = IW'(i) - hd_idx;
    end

    for (genvar s = 0; s < N_ST; s++) begin : g_port
        ldq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_search (
            .st_valid (st_valid[s]),
            .st_addr  (st_addr[s]),
            .st_size  (st_size[s]),
            .st_ltail (st_ltail[s]),
            .head     (s_q.head),
            .ent_live (live),
            .ent_addr (s_addr),
            .ent_size (s_size),
            .hit      (viol[s]),
            .bound    (bnd[s])
        );
    end

    ldq_pick #(.N_ST(N_ST), .PW(PW), .SW(SW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol    (viol),
        .bnd     (bnd),
        .any     (any_viol),
        .sel     (sel),
        .sel_bnd (sel_bnd)
    );

    always_comb begin
        s_d      = s_q;
        s_d.sq_v = 1'b0;

        if (ex_valid && s_q.slot[ex_idx].vld) begin
            s_d.slot[ex_idx].exe  = 1'b1;
            s_d.slot[ex_idx].addr = ex_addr;
            s_d.slot[ex_idx].size = ex_size;
        end

        if (cm_valid && s_q.slot[hd_idx].vld) begin
            s_d.slot[hd_idx].vld = 1'b0;
            s_d.slot[hd_idx].exe = 1'b0;
            s_d.head             = s_q.head + PW'(1);
        end

        if (any_viol) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ({1'b0, s_off[i]} >= sel_bnd) begin
                    s_d.slot[i].vld = 1'b0;
                    s_d.slot[i].exe = 1'b0;
                end
            end
            s_d.tail   = st_ltail[sel];
            s_d.sq_v   = 1'b1;
            s_d.sq_sid = st_sid[sel];
        end else if (disp_valid && !full) begin
            s_d.slot[tl_idx].vld = 1'b1;
            s_d.slot[tl_idx].exe = 1'b0;
            s_d.tail             = s_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign disp_ready   = !full;
    assign disp_tag     = s_q.tail;
    assign squash_valid = s_q.sq_v;
    assign squash_sid   = s_q.sq_sid;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));

    assert_full_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && disp_valid && !any_viol) |=> $stable(s_q.tail));

    assert_squash_from_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(|st_valid));

    assert_tail_slot_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (full || !s_q.slot[tl_idx].vld));

    for (genvar i = 0; i < DEPTH; i++) begin : g_win
        assert_window_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, s_off[i]} < count) |-> s_q.slot[i].vld);
    end

endmodule

// File: tb/sim_load_order_guard.sv
`timescale 1ns/1ps
module sim_load_order_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic disp_ready;
    logic [3:0] disp_tag;
    logic ex_valid = 1'b0;
    logic [3:0] ex_tag = '0;
    logic [31:0] ex_addr = '0;
    logic [1:0] ex_size = '0;
    logic cm_valid = 1'b0;
    logic [1:0] st_valid = '0;
    logic [1:0][31:0] st_addr = '0;
    logic [1:0][1:0] st_size = '0;
    logic [1:0][3:0] st_ltail = '0;
    logic [1:0][5:0] st_sid = '0;
    logic squash_valid;
    logic [5:0] squash_sid;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    string req_q[$];

    always #10 clk = ~clk;

    load_order_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_addr(ex_addr), .ex_size(ex_size),
        .cm_valid(cm_valid),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .st_ltail(st_ltail), .st_sid(st_sid),
        .squash_valid(squash_valid), .squash_sid(squash_sid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic dispatch(input int tag);
        chk("R2 dispatch tag", int'(disp_tag), tag);
        disp_valid = 1'b1;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic exec(input int tag, input int addr, input int sz);
        ex_valid = 1'b1;
        ex_tag   = 4'(tag);
        ex_addr  = 32'(addr);
        ex_size  = 2'(sz);
        step();
        ex_valid = 1'b0;
    endtask

    task automatic commit();
        cm_valid = 1'b1;
        step();
        cm_valid = 1'b0;
    endtask

    // exp: store id expected on squash, or -1 for no squash
    task automatic resolve(input bit v0, input int lt0, input int a0, input int z0, input int id0,
                           input bit v1, input int lt1, input int a1, input int z1, input int id1,
                           input bit dsp, input int exp, input string req);
        st_valid    = {v1, v0};
        st_ltail[0] = 4'(lt0); st_addr[0] = 32'(a0); st_size[0] = 2'(z0); st_sid[0] = 6'(id0);
        st_ltail[1] = 4'(lt1); st_addr[1] = 32'(a1); st_size[1] = 2'(z1); st_sid[1] = 6'(id1);
        disp_valid  = dsp;
        exp_q.push_back(exp);
        req_q.push_back(req);
        step();
        st_valid   = '0;
        disp_valid = 1'b0;
    endtask

    // Monitor: squash outcome is due at the falling edge right after the store cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                int act;
                act = squash_valid ? (256 + int'(squash_sid)) : 0;
                if (exp_q.size() > 0) begin
                    int e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(r, act, (e < 0) ? 0 : 256 + e);
                end else if (squash_valid) begin
                    chk("R5 unexpected squash", act, 0);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", int'(disp_ready), 1);
        chk("R1 tag", int'(disp_tag), 0);
        chk("R1 squash", int'(squash_valid), 0);

        // three loads, executed
        dispatch(0); dispatch(1); dispatch(2);
        exec(0, 'h100, 3);
        exec(1, 'h100, 2);
        exec(2, 'h200, 3);
        // R8 adjacent lanes, R6 older load overlaps
        resolve(1, 1, 'h104, 2, 3, 0, 0, 0, 0, 0, 0, -1, "R8/R6 no squash");
        // R5 overlap with younger executed load
        resolve(1, 1, 'h102, 1, 5, 0, 0, 0, 0, 0, 0, 5, "R5 squash id");
        chk("R10 tail rollback", int'(disp_tag), 1);
        // R10 discarded load 2 no longer matches
        resolve(1, 1, 'h200, 3, 6, 0, 0, 0, 0, 0, 0, -1, "R10 discarded load");
        commit();
        chk("R4 empty after commit", int'(disp_tag), 1);

        // R7 unexecuted load
        dispatch(1);
        resolve(1, 1, 'h600, 3, 7, 0, 0, 0, 0, 0, 0, -1, "R7 unexecuted load");
        exec(1, 'h600, 3);
        resolve(1, 1, 'h600, 3, 7, 0, 0, 0, 0, 0, 0, 7, "R5 after execute");
        chk("R10 tail after squash", int'(disp_tag), 1);

        // R3 fill to DEPTH
        for (int k = 1; k <= 8; k++) dispatch(k);
        chk("R3 ready low when full", int'(disp_ready), 0);
        disp_valid = 1'b1;
        step();
        disp_valid = 1'b0;
        chk("R3 tag held when full", int'(disp_tag), 9);
        chk("R3 still full", int'(disp_ready), 0);
        commit();
        chk("R4 ready after commit", int'(disp_ready), 1);

        // R9 two ports violate, nearer bound wins; R12 dispatch dropped
        exec(3, 'h300, 3);
        exec(4, 'h400, 2);
        exec(6, 'h400, 2);
        resolve(1, 5, 'h400, 0, 10, 1, 3, 'h304, 2, 11, 1, 11, "R9 oldest store");
        chk("R12 dispatch dropped", int'(disp_tag), 3);

        // R11 wraparound
        commit();
        for (int k = 3; k <= 9; k++) dispatch(k);
        exec(5, 'h500, 3);
        resolve(1, 8, 'h500, 0, 20, 0, 0, 0, 0, 0, 0, -1, "R11 older across wrap");
        exec(9, 'h500, 3);
        resolve(1, 8, 'h500, 0, 21, 0, 0, 0, 0, 0, 0, 21, "R11 younger across wrap");
        chk("R10 tail after wrap squash", int'(disp_tag), 8);

        // R9 tie on bound: lower port wins
        exec(6, 'h700, 3);
        resolve(1, 6, 'h700, 3, 30, 1, 6, 'h700, 3, 31, 0, 30, "R9 tie lower port");
        chk("R10 tail after tie", int'(disp_tag), 6);

        step();
        step();
        chk("R5 all squashes seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule